// File: doc/BRIEF.md
# Multicycle Integer Processor Core

This block is an unpipelined integer processor. It runs a small instruction subset: word load, word store, branch-if-equal, register-register arithmetic and logic operations, and register-immediate arithmetic and logic operations. Each instruction passes through a fixed sequence of phases, one clock each: fetch, decode with register read, execute or address generation, memory access with branch completion, and write-back. Results move from phase to phase through dedicated holding registers. These are the fetched word, the next sequential PC, the two source operands, the extended immediate, the ALU result, the branch condition and the loaded word. A 32-entry register file sits behind them.

The core has two memory ports. The instruction port reads only. The data port reads and writes. Both are simple single-cycle ports. The address is driven during one phase and the read word is sampled at the clock edge that ends that phase. A write commits at the edge that ends the phase in which it is requested. The ports have no handshake, so memory cannot apply back-pressure. The memory must return data in the same cycle and must accept every request. A one-cycle `retire` pulse marks the final phase of every instruction.

Top module: `mc_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 and the phase sequencer to fetch. While reset is held and in the first cycle after it, `imem_req` is 1, `imem_addr` is 0, and `dmem_we` and `retire` are 0.
- R2: After any non-branch instruction, the next fetch address is the previous fetch address plus 4.
- R3: Opcode 0110011 selects the register-register form. The operation is chosen by funct3 (bits 14:12) and funct7 bit 30: 000/0 ADD, 000/1 SUB, 111 AND, 110 OR, 100 XOR, 010 signed SLT. The result goes to rd (bits 11:7), using rs1 (bits 19:15) and rs2 (bits 24:20).
- R4: Opcode 0010011 selects the immediate form. It uses the sign-extended immediate in bits 31:20 and funct3 000 ADDI, 111 ANDI, 110 ORI, 100 XORI.
- R5: Opcode 0000011 loads the word at rs1 plus the I-immediate into rd. `dmem_re` is high only in the memory phase.
- R6: Opcode 0100011 writes rs2 to address rs1 plus the sign-extended split immediate {bits 31:25, bits 11:7}. `dmem_we` is high for exactly one cycle.
- R7: Opcode 1100011 compares rs1 and rs2 for equality. If they are equal, the next fetch is at PC+4 plus four times the sign-extended split immediate {bits 31:25, bits 11:7}. Otherwise the next fetch is at PC+4.
- R8: Register x0 reads as zero, and writes to it are discarded.
- R9: Any other opcode changes no register and no memory, and the next fetch is at PC+4.
- R10: `retire` is a single-cycle pulse in the last phase of each instruction. Counting the fetch cycle as 1, it comes in cycle 5 for register-writing instructions (R3, R4, R5) and in cycle 4 for all others.
- R11: `dmem_we` and `dmem_re` are never high together, and each is high only in the memory phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_req | output | 1 | High during the fetch phase |
| imem_addr | output | 32 | Fetch byte address (current PC) |
| imem_rdata | input | 32 | Instruction word for `imem_addr`, same cycle |
| dmem_re | output | 1 | Data read request (load) |
| dmem_we | output | 1 | Data write strobe (store) |
| dmem_addr | output | 32 | Data byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data for `dmem_addr`, same cycle |
| retire | output | 1 | Pulses in the final phase of each instruction |

## Verification
A store's write strobe appears in the fourth cycle after the instruction's fetch cycle (cycle 4 counting the fetch as 1). The bench therefore compares address and data with the head of its expected-store queue whenever `dmem_we` is high, rather than at a fixed time, and register results are brought out through those stores. Each fetch is compared with an expected fetch-order queue that the bench computes from the branch rules. `retire` is checked to land in cycle 5 or cycle 4 after fetch, as its opcode class demands. All outputs are sampled on the falling edge, half a period after the registers update.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int INSN_W = 32;

  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_IMM    = 7'b0010011;

  typedef enum logic [2:0] {
    PH_FETCH, PH_DECODE, PH_EXEC, PH_MEM, PH_WBACK
  } phase_t;

  typedef enum logic [2:0] {
    K_NOP, K_ALU_R, K_ALU_I, K_LOAD, K_STORE, K_BRANCH
  } kind_t;

  typedef enum logic [2:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SLT, OP_ZERO
  } alu_op_t;
endpackage

// File: rtl/mc_decode.sv
module mc_decode
  import mc_pkg::*;
#(
  parameter int XLEN = mc_pkg::XLEN,
  parameter int AW   = 5
) (
  input  logic [INSN_W-1:0] insn,
  output kind_t             kind,
  output alu_op_t           op,
  output logic [AW-1:0]     rs1,
  output logic [AW-1:0]     rs2,
  output logic [AW-1:0]     rd,
  output logic [XLEN-1:0]   imm
);
  localparam int EXT = XLEN - 12;

  logic [6:0] opc;
  logic [2:0] f3;
  logic [XLEN-1:0] imm_i, imm_s;

  assign opc = insn[6:0];
  assign f3  = insn[14:12];
  assign rd  = insn[7 +: AW];
  assign rs1 = insn[15 +: AW];
  assign rs2 = insn[20 +: AW];

  assign imm_i = {{EXT{insn[31]}}, insn[31:20]};
  assign imm_s = {{EXT{insn[31]}}, insn[31:25], insn[11:7]};

  always_comb begin
    unique case (opc)
      OPC_REG:    kind = K_ALU_R;
      OPC_IMM:    kind = K_ALU_I;
      OPC_LOAD:   kind = K_LOAD;
      OPC_STORE:  kind = K_STORE;
      OPC_BRANCH: kind = K_BRANCH;
      default:    kind = K_NOP;
    endcase
  end

  // split immediate serves both stores and branch offsets
  assign imm = (kind == K_STORE || kind == K_BRANCH) ? imm_s : imm_i;

  always_comb begin
    unique case (f3)
      3'b000:  op = (kind == K_ALU_R && insn[30]) ? OP_SUB : OP_ADD;
      3'b111:  op = OP_AND;
      3'b110:  op = OP_OR;
      3'b100:  op = OP_XOR;
      3'b010:  op = OP_SLT;
      default: op = OP_ZERO;
    endcase
  end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int XLEN = mc_pkg::XLEN
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_t         op,
  output logic [XLEN-1:0] y
);
  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_SLT:  y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int XLEN = mc_pkg::XLEN,
  parameter int NREG = mc_pkg::NREG,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic [AW-1:0]   ra1,
  input  logic [AW-1:0]   ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd
);
  logic [XLEN-1:0] cells [NREG];

  always_ff @(posedge clk) begin
    if (we && wa != '0) cells[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : cells[ra1];
  assign rd2 = (ra2 == '0) ? '0 : cells[ra2];
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int XLEN = mc_pkg::XLEN,
  parameter int NREG = mc_pkg::NREG
) (
  input  logic            clk,
  input  logic            rst,
  output logic            imem_req,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic            dmem_re,
  output logic            dmem_we,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            retire
);
  localparam int AW = $clog2(NREG);

  phase_t          phase;
  logic [XLEN-1:0] pc_q, npc_q, opa_q, opb_q, imm_q, res_q, lmd_q;
  logic [31:0]     ir_q;
  logic            cond_q;

  kind_t           kind;
  alu_op_t         dec_op, use_op;
  logic [AW-1:0]   rs1, rs2, rd;
  logic [XLEN-1:0] dec_imm, rf_a, rf_b, alu_x, alu_y, alu_out;
  logic            writes_reg, rf_we;

  mc_decode #(.XLEN(XLEN), .AW(AW)) u_dec (
    .insn(ir_q), .kind(kind), .op(dec_op),
    .rs1(rs1), .rs2(rs2), .rd(rd), .imm(dec_imm)
  );

  mc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .ra1(rs1), .ra2(rs2), .rd1(rf_a), .rd2(rf_b),
    .we(rf_we), .wa(rd), .wd((kind == K_LOAD) ? lmd_q : res_q)
  );

  // operand steering for the single ALU
  always_comb begin
    alu_x  = opa_q;
    alu_y  = imm_q;
    use_op = OP_ADD;
    unique case (kind)
      K_ALU_R:  begin alu_y = opb_q; use_op = dec_op; end
      K_ALU_I:  use_op = dec_op;
      K_BRANCH: begin alu_x = npc_q; alu_y = imm_q << 2; end
      default:  ;
    endcase
  end

  mc_alu #(.XLEN(XLEN)) u_alu (.a(alu_x), .b(alu_y), .op(use_op), .y(alu_out));

  assign writes_reg = (kind == K_ALU_R) || (kind == K_ALU_I) || (kind == K_LOAD);
  assign rf_we      = (phase == PH_WBACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_FETCH;
      pc_q   <= '0;
      npc_q  <= '0;
      ir_q   <= '0;
      opa_q  <= '0;
      opb_q  <= '0;
      imm_q  <= '0;
      res_q  <= '0;
      lmd_q  <= '0;
      cond_q <= 1'b0;
    end else begin
      unique case (phase)
        PH_FETCH: begin
          ir_q  <= imem_rdata;
          npc_q <= pc_q + XLEN'(4);
          phase <= PH_DECODE;
        end
        PH_DECODE: begin
          opa_q <= rf_a;
          opb_q <= rf_b;
          imm_q <= dec_imm;
          phase <= PH_EXEC;
        end
        PH_EXEC: begin
          res_q  <= alu_out;
          cond_q <= (opa_q == opb_q);
          phase  <= PH_MEM;
        end
        PH_MEM: begin
          pc_q <= (kind == K_BRANCH && cond_q) ? res_q : npc_q;
          if (kind == K_LOAD) lmd_q <= dmem_rdata;
          phase <= writes_reg ? PH_WBACK : PH_FETCH;
        end
        default: phase <= PH_FETCH;
      endcase
    end
  end

  assign imem_req   = (phase == PH_FETCH);
  assign imem_addr  = pc_q;
  assign dmem_addr  = res_q;
  assign dmem_wdata = opb_q;
  assign dmem_re    = (phase == PH_MEM) && (kind == K_LOAD);
  assign dmem_we    = (phase == PH_MEM) && (kind == K_STORE);
  assign retire     = (phase == PH_WBACK) || (phase == PH_MEM && !writes_reg);

  // ---- checking support: previous fetch address and branch flag
  logic [XLEN-1:0] chk_prev_pc;
  logic            chk_have, chk_prev_br;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_prev_pc <= '0;
      chk_have    <= 1'b0;
      chk_prev_br <= 1'b0;
    end else begin
      if (imem_req) begin
        chk_prev_pc <= imem_addr;
        chk_have    <= 1'b1;
      end
      if (retire) chk_prev_br <= (kind == K_BRANCH);
    end
  end

  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (imem_req && imem_addr == '0 && !retire));

  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (imem_req && chk_have && !chk_prev_br) |-> imem_addr == chk_prev_pc + XLEN'(4));

  p_taken_target_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MEM && kind == K_BRANCH && cond_q) |=> imem_addr == $past(dmem_addr));

  p_retire_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    retire |=> !retire);

  p_mem_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
    !(dmem_we && dmem_re));

  p_mem_only_in_phase_r11: assert property (@(posedge clk) disable iff (rst)
    (dmem_we || dmem_re) |=> imem_req || phase == PH_WBACK);
endmodule

// File: tb/tb_mc_core.sv
module tb_mc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_req, dmem_re, dmem_we, retire;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;

  always #4 clk = ~clk;  // 125 MHz

  mc_core dut (
    .clk(clk), .rst(rst), .imem_req(imem_req), .imem_addr(imem_addr),
    .imem_rdata(imem_rdata), .dmem_re(dmem_re), .dmem_we(dmem_we),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .retire(retire)
  );

  logic [31:0] prog [64];
  logic [31:0] dm   [64];
  assign imem_rdata = prog[imem_addr[7:2]];
  assign dmem_rdata = dm[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 64; k++) dm[k] <= 32'h0;
      dm[16] <= 32'h1234_5678;
      dm[17] <= 32'hFFFF_FFF0;
    end else if (dmem_we) dm[dmem_addr[7:2]] <= dmem_wdata;
  end

  int checks = 0, fails = 0, cycle = 0;
  logic [63:0] st_q [$];
  logic [31:0] fe_q [$];
  always @(posedge clk) cycle <= cycle + 1;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_store(input logic [31:0] a, input logic [31:0] d);
    st_q.push_back({a, d});
  endtask

  function automatic logic [31:0] e_r(input logic [6:0] f7, input int s2, input int s1,
                                      input logic [2:0] f3, input int d);
    return {f7, 5'(s2), 5'(s1), f3, 5'(d), 7'b0110011};
  endfunction
  function automatic logic [31:0] e_i(input logic [6:0] opc, input int imm, input int s1,
                                      input logic [2:0] f3, input int d);
    return {12'(imm), 5'(s1), f3, 5'(d), opc};
  endfunction
  function automatic logic [31:0] e_s(input logic [6:0] opc, input int imm, input int s2,
                                      input int s1);
    logic [11:0] v;
    v = 12'(imm);
    return {v[11:5], 5'(s2), 5'(s1), (opc == 7'b0100011) ? 3'b010 : 3'b000, v[4:0], opc};
  endfunction

  // monitor: stores, fetch order, retire timing
  int   f_cycle = 0, exp_len = 0;
  logic pend = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (dmem_we) begin
        if (st_q.size() == 0) check("R6 unexpected store", {dmem_addr, dmem_wdata}, 64'h0);
        else check("R3/R4/R5/R6/R8/R9 store", {dmem_addr, dmem_wdata}, st_q.pop_front());
      end
      if (imem_req) begin
        if (fe_q.size() != 0) check("R2/R7/R9 fetch", {32'h0, imem_addr}, {32'h0, fe_q.pop_front()});
        f_cycle = cycle;
        pend    = 1'b1;
        case (prog[imem_addr[7:2]][6:0])
          7'b0110011, 7'b0010011, 7'b0000011: exp_len = 5;
          default: exp_len = 4;
        endcase
      end
      if (retire) begin
        check("R10 retire cycle", 64'(pend ? cycle - f_cycle + 1 : 0), 64'(exp_len));
        pend = 1'b0;
      end
    end
  end

  initial begin
    for (int k = 0; k < 64; k++) prog[k] = e_s(7'b1100011, -1, 0, 0);
    prog[0]  = e_i(7'b0010011, 5, 0, 3'b000, 1);
    prog[1]  = e_i(7'b0010011, -3, 0, 3'b000, 2);
    prog[2]  = e_r(7'h00, 2, 1, 3'b000, 3);
    prog[3]  = e_s(7'b0100011, 'h80, 3, 0);
    prog[4]  = e_r(7'h20, 2, 1, 3'b000, 4);
    prog[5]  = e_s(7'b0100011, 'h84, 4, 0);
    prog[6]  = e_r(7'h00, 2, 1, 3'b111, 5);
    prog[7]  = e_s(7'b0100011, 'h88, 5, 0);
    prog[8]  = e_r(7'h00, 2, 1, 3'b110, 6);
    prog[9]  = e_s(7'b0100011, 'h8C, 6, 0);
    prog[10] = e_r(7'h00, 2, 1, 3'b100, 7);
    prog[11] = e_s(7'b0100011, 'h90, 7, 0);
    prog[12] = e_r(7'h00, 1, 2, 3'b010, 8);
    prog[13] = e_r(7'h00, 2, 1, 3'b010, 9);
    prog[14] = e_s(7'b0100011, 'h94, 8, 0);
    prog[15] = e_s(7'b0100011, 'h98, 9, 0);
    prog[16] = e_i(7'b0010011, 'hF0, 2, 3'b111, 10);
    prog[17] = e_i(7'b0010011, -16, 1, 3'b110, 11);
    prog[18] = e_i(7'b0010011, 'h7FF, 1, 3'b100, 12);
    prog[19] = e_s(7'b0100011, 'h9C, 10, 0);
    prog[20] = e_s(7'b0100011, 'hA0, 11, 0);
    prog[21] = e_s(7'b0100011, 'hA4, 12, 0);
    prog[22] = e_i(7'b0000011, 'h40, 0, 3'b010, 13);
    prog[23] = e_i(7'b0010011, 'h20, 0, 3'b000, 15);
    prog[24] = e_i(7'b0000011, 'h24, 15, 3'b010, 14);
    prog[25] = e_s(7'b0100011, 'hA8, 13, 0);
    prog[26] = e_s(7'b0100011, -4, 14, 15);
    prog[27] = e_i(7'b0010011, 77, 0, 3'b000, 0);
    prog[28] = e_s(7'b0100011, 'hAC, 0, 0);
    prog[29] = 32'hFFFF_FFFF;
    prog[30] = e_s(7'b0100011, 'hB0, 1, 0);
    prog[31] = e_s(7'b1100011, 3, 2, 1);
    prog[32] = e_s(7'b1100011, 2, 1, 1);
    prog[33] = e_s(7'b0100011, 'hB4, 1, 0);
    prog[34] = e_s(7'b0100011, 'hB8, 1, 0);
    prog[35] = e_s(7'b0100011, 'hBC, 2, 0);
    prog[36] = e_s(7'b1100011, 2, 0, 0);
    prog[37] = e_s(7'b0100011, 'hC0, 3, 0);
    prog[38] = e_s(7'b1100011, 1, 0, 0);
    prog[39] = e_s(7'b1100011, -3, 0, 0);
    prog[40] = e_s(7'b1100011, -1, 0, 0);

    // expected stores (R3 R4 R5 R6 R8 R9 R7)
    expect_store(32'h80, 32'h2);           // R3 ADD
    expect_store(32'h84, 32'h8);           // R3 SUB
    expect_store(32'h88, 32'h5);           // R3 AND
    expect_store(32'h8C, 32'hFFFF_FFFD);   // R3 OR
    expect_store(32'h90, 32'hFFFF_FFF8);   // R3 XOR
    expect_store(32'h94, 32'h1);           // R3 SLT true
    expect_store(32'h98, 32'h0);           // R3 SLT false
    expect_store(32'h9C, 32'hF0);          // R4 ANDI
    expect_store(32'hA0, 32'hFFFF_FFF5);   // R4 ORI negative imm
    expect_store(32'hA4, 32'h7FA);         // R4 XORI
    expect_store(32'hA8, 32'h1234_5678);   // R5 load
    expect_store(32'h1C, 32'hFFFF_FFF0);   // R5 load, R6 negative split imm
    expect_store(32'hAC, 32'h0);           // R8 x0
    expect_store(32'hB0, 32'h5);           // R9 no-op left x1 intact
    expect_store(32'hBC, 32'hFFFF_FFFD);   // R7 taken branch skipped 33, 34
    expect_store(32'hC0, 32'h2);           // R7 backward branch
    for (int k = 0; k <= 32; k++) fe_q.push_back(32'(4 * k));
    fe_q.push_back(32'd140); fe_q.push_back(32'd144); fe_q.push_back(32'd156);
    fe_q.push_back(32'd148); fe_q.push_back(32'd152); fe_q.push_back(32'd160);

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset fetch addr", {32'h0, imem_addr}, 64'h0);
    check("R1 reset req/we/retire", {61'h0, imem_req, dmem_we, retire}, 64'h4);
    rst = 1'b0;
    begin
      int wd = 0;
      while ((st_q.size() != 0 || fe_q.size() != 0) && wd < 5000) begin
        @(negedge clk);
        wd++;
      end
      repeat (20) @(negedge clk);
      if (wd >= 5000) check("watchdog", 64'h1, 64'h0);
    end
    check("R6 store queue drained", 64'(st_q.size()), 64'h0);
    check("R11 no request at rest", {62'h0, dmem_we, dmem_re}, 64'h0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule